// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Flags and Flow Control

This block receives characters from an asynchronous serial line. It samples the line at sixteen ticks per bit. The tick rate comes from a programmable clock divider. The block finds each start bit, collects 5 to 8 data bits with the least significant bit first, checks an optional parity bit, and checks one or two stop bits. Each character is stored in a small receive queue. Four error flags are stored with each character: overrun, parity, frame and break.

Software or a DMA engine empties the queue through a read strobe. Each read returns the oldest character and its flags one cycle later. A status output shows that unread data is waiting. An idle time-out is raised when characters sit in the queue and no new character arrives for a programmed number of frame times. An active-low request-to-send output tells the remote sender to pause as the queue nears full. This output uses hysteresis.

Top module: `serial_rx_core`

## Requirements
- R1: A character has a low start bit, then `data_bits`+5 data bits (0 selects 5 bits, 3 selects 8 bits) with the least significant bit first, then an optional parity bit, then one stop bit, or two when `two_stop`=1. Unused upper bits of `rd_data` read as 0.
- R2: A falling edge becomes a start bit only if the line is still low 8 ticks later. A shorter low pulse stores no character.
- R3: When `parity_en`=1, the parity flag is set if the received parity bit does not match the configured parity. With `parity_odd`=0 the data bits plus the parity bit must hold an even number of ones. With `parity_odd`=1 they must hold an odd number of ones.
- R4: The frame flag is set when any stop bit is sampled low. The receiver then waits for the line to go high before it looks for a new start bit.
- R5: A frame where every data, parity and stop sample is low is stored as data 0 with both the break flag and the frame flag set.
- R6: If a character completes while the queue holds `DEPTH` entries and no read happens in that cycle, it replaces the newest entry and its overrun flag is set. The entry count stays at `DEPTH`.
- R7: A read strobe on a non-empty queue makes `rd_valid` high in the next cycle. `rd_data` and the flags then show the oldest entry, in arrival order. A read strobe on an empty queue gives no `rd_valid`.
- R8: `rx_avail` is high exactly while the queue holds at least one unread entry.
- R9: `rx_timeout` rises when the queue is non-empty and no character has been stored and no read has happened for `timeout_frames` frame times. A stored character, a read or an empty queue clears it. A value of 0 disables it.
- R10: `rts_n` goes low when free space is more than 2 entries. It goes high when free space is 0. In between it holds its value.
- R11: After reset the queue is empty, `rx_avail`, `rd_valid` and `rx_timeout` are 0, and `rts_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_div | input | DIV_W | One oversampling tick every baud_div+1 clocks |
| data_bits | input | 2 | Data length minus 5 |
| parity_en | input | 1 | A parity bit follows the data |
| parity_odd | input | 1 | 1 = odd parity, 0 = even parity |
| two_stop | input | 1 | Check two stop bits |
| timeout_frames | input | TO_W | Idle frame times before time-out; 0 disables it |
| rxd | input | 1 | Serial input, asynchronous to clk |
| rd_en | input | 1 | Read strobe for the oldest entry |
| rd_valid | output | 1 | Read result is valid this cycle |
| rd_data | output | 8 | Character that was read |
| rd_overrun | output | 1 | Overrun flag of the character that was read |
| rd_parity_err | output | 1 | Parity flag of the character that was read |
| rd_frame_err | output | 1 | Frame flag of the character that was read |
| rd_break | output | 1 | Break flag of the character that was read |
| rx_avail | output | 1 | Unread data is waiting |
| rx_timeout | output | 1 | Idle time-out with data waiting |
| rts_n | output | 1 | Active-low request-to-send |

## Verification
The bench sends clean 8-bit frames, 5-bit frames where the upper bits are driven high, and frames with even and odd parity. Mismatched parity must be flagged, and a 5-bit frame must drop the bits the line carried past its length. Frames with a low first or second stop bit must set only the frame flag. A held-low line must produce a single break entry, and a short low glitch must store nothing. Filling the queue past its depth checks three things: the newest entry is replaced, `rts_n` switches at each hysteresis threshold, and the idle time-out stays low before its window ends and rises after it.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef struct packed {
    logic [7:0] data;
    logic       ovr;
    logic       par;
    logic       frm;
    logic       brk;
  } rx_word_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP1, ST_STOP2, ST_WAITHI
  } rx_state_t;
endpackage

// File: rtl/serial_rx_tick.sv
module serial_rx_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || cnt >= div) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  assign tick = !rst && (cnt >= div);
endmodule

// File: rtl/serial_rx_frame.sv
module serial_rx_frame
  import serial_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       rxs,
  input  logic [1:0] data_bits,
  input  logic       parity_en,
  input  logic       parity_odd,
  input  logic       two_stop,
  output logic       push,
  output rx_word_t   push_word
);
  rx_state_t  state;
  logic [3:0] cnt;
  logic [2:0] idx;
  logic [7:0] shreg;
  logic       par_bit;
  logic       all_zero;
  logic       mid;
  logic       finish;
  rx_word_t   word_c;

  assign mid    = tick && (cnt == 4'd15);
  assign finish = mid && ((state == ST_STOP1 && !(two_stop && rxs)) || state == ST_STOP2);

  always_comb begin
    word_c.data = shreg;
    word_c.ovr  = 1'b0;
    word_c.brk  = !rxs && all_zero;
    word_c.frm  = !rxs;
    word_c.par  = parity_en && !word_c.brk && (par_bit != (parity_odd ^ (^shreg)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE; cnt <= '0; idx <= '0; shreg <= '0;
      par_bit <= 1'b0; all_zero <= 1'b1; push <= 1'b0; push_word <= '0;
    end else begin
      push <= 1'b0;
      if (finish) begin
        push      <= 1'b1;
        push_word <= word_c;
        state     <= rxs ? ST_IDLE : ST_WAITHI;
        cnt       <= '0;
      end else if (tick) begin
        case (state)
          ST_IDLE: if (!rxs) begin
            state <= ST_START; cnt <= '0; shreg <= '0; all_zero <= 1'b1; par_bit <= 1'b0;
          end
          ST_START: begin
            if (cnt == 4'd7) begin
              cnt <= '0; idx <= '0;
              state <= rxs ? ST_IDLE : ST_DATA;
            end else cnt <= cnt + 1'b1;
          end
          ST_DATA: begin
            if (cnt == 4'd15) begin
              cnt <= '0;
              shreg[idx] <= rxs;
              all_zero <= all_zero && !rxs;
              if (idx == {1'b0, data_bits} + 3'd4) state <= parity_en ? ST_PAR : ST_STOP1;
              else idx <= idx + 1'b1;
            end else cnt <= cnt + 1'b1;
          end
          ST_PAR: begin
            if (cnt == 4'd15) begin
              cnt <= '0; par_bit <= rxs; all_zero <= all_zero && !rxs; state <= ST_STOP1;
            end else cnt <= cnt + 1'b1;
          end
          ST_STOP1: begin
            if (cnt == 4'd15) begin cnt <= '0; state <= ST_STOP2; end
            else cnt <= cnt + 1'b1;
          end
          ST_STOP2: cnt <= cnt + 1'b1;
          ST_WAITHI: if (rxs) state <= ST_IDLE;
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R5: a stored break entry carries the frame flag and a zero character
  a_r5_break_word: assert property (@(posedge clk) disable iff (rst)
    (push && push_word.brk) |-> (push_word.frm && push_word.data == 8'd0));
  // R2: a start that is high again at the eighth tick is dropped
  a_r2_false_start: assert property (@(posedge clk) disable iff (rst)
    (state == ST_START && tick && cnt == 4'd7 && rxs) |=> (state == ST_IDLE));
  // R4: after a low stop bit the receiver does not look for a start bit
  a_r4_wait_high: assert property (@(posedge clk) disable iff (rst)
    (finish && !rxs) |=> (state == ST_WAITHI));
endmodule

// File: rtl/serial_rx_fifo.sv
module serial_rx_fifo
  import serial_rx_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  rx_word_t      push_word,
  input  logic          pop,
  output rx_word_t      q,
  output logic          q_valid,
  output logic [CW-1:0] count
);
  rx_word_t        mem [DEPTH];
  logic [AW-1:0]   wr_ptr, rd_ptr;
  logic            do_pop, full_hit, we;
  logic [AW-1:0]   waddr;
  rx_word_t        wdata;

  assign do_pop   = pop && (count != '0);
  assign full_hit = push && (count == CW'(DEPTH)) && !do_pop;
  assign we       = push;
  assign waddr    = full_hit ? (wr_ptr - 1'b1) : wr_ptr;

  always_comb begin
    wdata     = push_word;
    wdata.ovr = full_hit;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (do_pop) q <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0; rd_ptr <= '0; count <= '0; q_valid <= 1'b0;
    end else begin
      q_valid <= do_pop;
      if (push && !full_hit) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)            rd_ptr <= rd_ptr + 1'b1;
      if ((push && !full_hit) && !do_pop)      count <= count + 1'b1;
      else if (do_pop && !(push && !full_hit)) count <= count - 1'b1;
    end
  end

  // R6: the count never exceeds the queue depth
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst) count <= CW'(DEPTH));
  // R6: an overrun keeps the queue full
  a_r6_overrun_full: assert property (@(posedge clk) disable iff (rst)
    full_hit |=> (count == CW'(DEPTH)));
  // R7: a read of an empty queue yields nothing
  a_r7_empty_read: assert property (@(posedge clk) disable iff (rst)
    (pop && count == '0) |=> !q_valid);
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
  import serial_rx_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DIV_W = 16,
  parameter int TO_W  = 4,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] baud_div,
  input  logic [1:0]       data_bits,
  input  logic             parity_en,
  input  logic             parity_odd,
  input  logic             two_stop,
  input  logic [TO_W-1:0]  timeout_frames,
  input  logic             rxd,
  input  logic             rd_en,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  output logic             rd_overrun,
  output logic             rd_parity_err,
  output logic             rd_frame_err,
  output logic             rd_break,
  output logic             rx_avail,
  output logic             rx_timeout,
  output logic             rts_n
);
  logic          sync1, rxs, tick, push;
  rx_word_t      push_word, q;
  logic [CW-1:0] count;
  logic [3:0]    frame_bits;
  logic [7:0]    frame_ticks, tcnt;
  logic [TO_W-1:0] fcnt;

  always_ff @(posedge clk) begin
    if (rst) begin sync1 <= 1'b1; rxs <= 1'b1; end
    else     begin sync1 <= rxd;  rxs <= sync1; end
  end

  serial_rx_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst(rst), .div(baud_div), .tick(tick));

  serial_rx_frame u_frame (
    .clk(clk), .rst(rst), .tick(tick), .rxs(rxs), .data_bits(data_bits),
    .parity_en(parity_en), .parity_odd(parity_odd), .two_stop(two_stop),
    .push(push), .push_word(push_word));

  serial_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(push), .push_word(push_word), .pop(rd_en),
    .q(q), .q_valid(rd_valid), .count(count));

  assign rd_data       = q.data;
  assign rd_overrun    = q.ovr;
  assign rd_parity_err = q.par;
  assign rd_frame_err  = q.frm;
  assign rd_break      = q.brk;
  assign rx_avail      = (count != '0);

  assign frame_bits  = 4'd7 + {2'b00, data_bits} + {3'b000, parity_en} + {3'b000, two_stop};
  assign frame_ticks = {frame_bits, 4'b0000};

  always_ff @(posedge clk) begin
    if (rst || push || (rd_en && count != '0) || count == '0 || timeout_frames == '0) begin
      tcnt <= '0; fcnt <= '0; rx_timeout <= 1'b0;
    end else if (tick && !rx_timeout) begin
      if (tcnt == frame_ticks - 8'd1) begin
        tcnt <= '0;
        if (fcnt == timeout_frames - 1'b1) rx_timeout <= 1'b1;
        else fcnt <= fcnt + 1'b1;
      end else tcnt <= tcnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                              rts_n <= 1'b0;
    else if (count == CW'(DEPTH))         rts_n <= 1'b1;
    else if (count <= CW'(DEPTH - 3))     rts_n <= 1'b0;
  end

  // R10: a full queue raises rts_n one cycle later
  a_r10_rts_full: assert property (@(posedge clk) disable iff (rst)
    (count == CW'(DEPTH)) |=> rts_n);
  // R10: ample room lowers rts_n one cycle later
  a_r10_rts_room: assert property (@(posedge clk) disable iff (rst)
    (count <= CW'(DEPTH - 3)) |=> !rts_n);
  // R9: a time-out is only shown while data waits
  a_r9_timeout_data: assert property (@(posedge clk) disable iff (rst)
    rx_timeout |-> rx_avail);
  // R9: a read removes the time-out
  a_r9_read_clears: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rx_avail) |=> !rx_timeout);
endmodule

// File: tb/serial_rx_core_bench.sv
module serial_rx_core_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int DIV   = 3;
  localparam int BIT   = 16 * (DIV + 1);

  logic clk = 1'b0, rst = 1'b1;
  logic [15:0] baud_div = 16'(DIV);
  logic [1:0] data_bits = 2'd3;
  logic parity_en = 1'b0, parity_odd = 1'b0, two_stop = 1'b0;
  logic [3:0] timeout_frames = 4'd2;
  logic rxd = 1'b1, rd_en = 1'b0;
  logic rd_valid, rd_overrun, rd_parity_err, rd_frame_err, rd_break;
  logic rx_avail, rx_timeout, rts_n;
  logic [7:0] rd_data;

  int checks = 0, fails = 0;
  logic [11:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_rx_core #(.DEPTH(DEPTH)) u_serial_rx_core (
    .clk(clk), .rst(rst), .baud_div(baud_div), .data_bits(data_bits),
    .parity_en(parity_en), .parity_odd(parity_odd), .two_stop(two_stop),
    .timeout_frames(timeout_frames), .rxd(rxd), .rd_en(rd_en),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_overrun(rd_overrun),
    .rd_parity_err(rd_parity_err), .rd_frame_err(rd_frame_err), .rd_break(rd_break),
    .rx_avail(rx_avail), .rx_timeout(rx_timeout), .rts_n(rts_n));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compares every read result with the oldest expectation
  always @(negedge clk) begin
    if (rd_valid) begin
      if (exp_q.size() == 0) check("R7 unexpected read", 32'(rd_data), 32'hFFFF_FFFF);
      else check(tag_q.pop_front(),
                 32'({rd_data, rd_overrun, rd_parity_err, rd_frame_err, rd_break}),
                 32'(exp_q.pop_front()));
    end
  end

  function automatic logic par_of(input logic [7:0] d, input int nb, input logic odd);
    logic p = odd;
    for (int i = 0; i < nb; i++) p ^= d[i];
    return p;
  endfunction

  task automatic hold(input logic v, input int bits);
    rxd = v;
    repeat (bits * BIT) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input int nb, input logic pbit,
                      input logic s1, input logic s2);
    hold(1'b0, 1);
    for (int i = 0; i < nb; i++) hold(d[i], 1);
    if (parity_en) hold(pbit, 1);
    hold(s1, 1);
    if (two_stop && s1) hold(s2, 1);
    hold(1'b1, 2);
  endtask

  task automatic expect_word(input string tag, input logic [7:0] d, input logic [3:0] fl);
    exp_q.push_back({d, fl});
    tag_q.push_back(tag);
  endtask

  task automatic drain(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rd_en = 1'b1;
      @(negedge clk); rd_en = 1'b0;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check("R11 rx_avail", 32'(rx_avail), 0);
    check("R11 rts_n", 32'(rts_n), 0);
    check("R11 rx_timeout", 32'(rx_timeout), 0);
    check("R11 rd_valid", 32'(rd_valid), 0);
    // R7 read of empty queue ignored
    drain(1);
    // R1 plain 8-bit frames
    expect_word("R1 8N1 A5", 8'hA5, 4'b0000); send(8'hA5, 8, 1'b0, 1'b1, 1'b1);
    check("R8 avail after char", 32'(rx_avail), 1);
    drain(1);
    check("R8 avail after read", 32'(rx_avail), 0);
    expect_word("R1 8N1 3C", 8'h3C, 4'b0000); send(8'h3C, 8, 1'b0, 1'b1, 1'b1);
    drain(1);
    // R1 5-bit frame, upper line bits high are not part of the character
    data_bits = 2'd0;
    expect_word("R1 5-bit", 8'h15, 4'b0000); send(8'hF5, 5, 1'b0, 1'b1, 1'b1);
    drain(1);
    data_bits = 2'd3;
    // R3 parity
    parity_en = 1'b1; parity_odd = 1'b0;
    expect_word("R3 even ok", 8'h5A, 4'b0000); send(8'h5A, 8, par_of(8'h5A, 8, 1'b0), 1'b1, 1'b1);
    expect_word("R3 even bad", 8'h5A, 4'b0100); send(8'h5A, 8, ~par_of(8'h5A, 8, 1'b0), 1'b1, 1'b1);
    parity_odd = 1'b1;
    expect_word("R3 odd ok", 8'h07, 4'b0000); send(8'h07, 8, par_of(8'h07, 8, 1'b1), 1'b1, 1'b1);
    expect_word("R3 odd bad", 8'h07, 4'b0100); send(8'h07, 8, ~par_of(8'h07, 8, 1'b1), 1'b1, 1'b1);
    drain(4);
    parity_en = 1'b0; parity_odd = 1'b0;
    // R4 frame errors, one and two stop bits
    expect_word("R4 stop low", 8'h81, 4'b0010); send(8'h81, 8, 1'b0, 1'b0, 1'b1);
    two_stop = 1'b1;
    expect_word("R4 second stop low", 8'h42, 4'b0010); send(8'h42, 8, 1'b0, 1'b1, 1'b0);
    expect_word("R1 two stop ok", 8'h99, 4'b0000); send(8'h99, 8, 1'b0, 1'b1, 1'b1);
    two_stop = 1'b0;
    drain(3);
    // R5 break: line low well past a frame, one entry only
    expect_word("R5 break", 8'h00, 4'b0011);
    hold(1'b0, 25); hold(1'b1, 2);
    drain(1);
    check("R5 single break entry", 32'(rx_avail), 0);
    // R2 short glitch ignored
    rxd = 1'b0; repeat (4 * (DIV + 1)) @(negedge clk);
    hold(1'b1, 24);
    check("R2 glitch stores nothing", 32'(rx_avail), 0);
    // R9 idle time-out, 2 frames of 10 bits
    expect_word("R9 char", 8'h11, 4'b0000); send(8'h11, 8, 1'b0, 1'b1, 1'b1);
    hold(1'b1, 10);
    check("R9 not yet", 32'(rx_timeout), 0);
    hold(1'b1, 15);
    check("R9 raised", 32'(rx_timeout), 1);
    drain(1);
    check("R9 cleared by read", 32'(rx_timeout), 0);
    // R6 and R10 fill the queue and overrun it
    for (int i = 0; i < DEPTH; i++) begin
      expect_word("R6 fill", 8'(8'h10 + i), 4'b0000);
      send(8'(8'h10 + i), 8, 1'b0, 1'b1, 1'b1);
      if (i == 4) check("R10 free 3 asserted", 32'(rts_n), 0);
      if (i == 5) check("R10 free 2 holds", 32'(rts_n), 0);
    end
    check("R10 full deasserted", 32'(rts_n), 1);
    void'(exp_q.pop_back()); void'(tag_q.pop_back());
    expect_word("R6 overrun replaces newest", 8'h18, 4'b1000);
    send(8'h18, 8, 1'b0, 1'b1, 1'b1);
    drain(1);
    check("R10 free 1 holds high", 32'(rts_n), 1);
    drain(3);
    check("R10 free 4 asserted", 32'(rts_n), 0);
    drain(4);
    check("R8 empty after drain", 32'(rx_avail), 0);
    check("R7 all results seen", 32'(exp_q.size()), 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule